// File: doc/BRIEF.md
# Posted Write Buffer with Shared Address/Data Bus Issue

This block sits between a processor core and a system bus. The core hands it 64-bit writes and the block posts them into a four-entry FIFO, so the core keeps running while memory is updated. An issue engine drains the FIFO onto one 64-bit bus that carries addresses and data in turn. A 9-bit command bus runs beside it and tags every cycle.

A single store of one to eight bytes uses one entry. It goes out as one address cycle and then one data cycle. A cache-line writeback is loaded as four beats that fill the whole buffer. It goes out as one block: a single address cycle, then four data cycles back to back. The block makes a per-lane parity byte for the bus and a parity bit for the command. The address cycle is held until an external write-ready input is seen high.

The core side uses a stall output. A write is taken on a clock edge where `wr_valid_i` is high and `wr_stall_o` is low.

Top module: `post_write_buffer`

## Requirements
- R1: After reset the buffer is empty, `sys_drv_o` is low, `sys_cmd_o` is all zero (no valid cycle) and `wr_stall_o` is low for a single store.
- R2: Single stores (`wr_block_i`=0) are accepted without waiting while fewer than four entries are held. With four entries held, `wr_stall_o` is high for a single store.
- R3: Entries leave in the order they were accepted. The bus shows each entry's address and data in that order.
- R4: A single store is issued as an address cycle followed by one data cycle. The address cycle has `sys_ad_o`=address and command bits [7]=0, [6:4]=001, [3]=0, [2:0]=byte count minus one (taken from `wr_nb_m1_i`). The data cycle has `sys_ad_o`=data and command bits [7]=1, [6:4]=000, [3]=1 (last), [2:0]=000.
- R5: While an address cycle is on the bus and `wr_rdy_i` is low at a clock edge, the next cycle shows the same address and command. The bus leaves the address cycle only after an edge where `wr_rdy_i` is high.
- R6: `sys_chk_o[i]` is the XOR of `sys_ad_o[8i+7:8i]` for every byte lane i.
- R7: `sys_cmd_o[8]` is the XOR of `sys_cmd_o[7:0]`, so the 9 command bits always have even parity.
- R8: The first beat of a line writeback (`wr_block_i`=1) is refused while any entry is held. Nothing of the block is issued until all four beats are loaded. The block then goes out as one address cycle (address of the first beat, bits [7]=0, [6:4]=010, [3]=0, [2:0]=000) followed by four data cycles in load order, with bit [3] set only on the fourth.
- R9: From the first accepted block beat until the block's last data cycle, single stores get `wr_stall_o` high. A fifth block beat is refused as well.
- R10: Data cycles are not gated by `wr_rdy_i`. Each data cycle of a block follows the previous one on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Core presents a write |
| wr_block_i | input | 1 | Write is one beat of a line writeback |
| wr_addr_i | input | 64 | Write address |
| wr_data_i | input | 64 | Write data, lane aligned |
| wr_nb_m1_i | input | 3 | Byte count minus one for a single store |
| wr_stall_o | output | 1 | Write refused this cycle |
| wr_rdy_i | input | 1 | External side can accept a write request |
| sys_ad_o | output | 64 | Shared address/data bus |
| sys_chk_o | output | 8 | Even parity per byte lane of the bus |
| sys_cmd_o | output | 9 | Command tag with parity in bit 8 |
| sys_drv_o | output | 1 | A valid cycle is on the bus |

## Verification
If the FIFO pointers or the count go wrong, the bus shows a wrong or repeated address or data word on the very next issued transaction. A wrong count also shows up on `wr_stall_o` in the same cycle as a refused or wrongly accepted write. If the block lock gets stuck, singles stay stalled forever. If it is released too early, a single store's address cycle appears between block data cycles. Both show within a few cycles of the block's final beat. A corrupted issue state shows as a command tag that breaks the address-then-data order, or as an address that changes while write-ready is low, on the cycle right after the fault.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int BUS_W = 64;
  localparam int NB_W  = 3;

  localparam logic [2:0] TYP_SINGLE = 3'b001;
  localparam logic [2:0] TYP_BLOCK  = 3'b010;

  typedef struct packed {
    logic [BUS_W-1:0] addr;
    logic [BUS_W-1:0] data;
    logic [NB_W-1:0]  nb_m1;
  } ent_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} iss_st_e;
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo
  import pwb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  ent_t          entry_i,
  input  logic          pop_i,
  output ent_t          head_o,
  output logic [CW-1:0] count_o
);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  ent_t          mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= entry_i;
  end

  assign head_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q != CW'(DEPTH)));
  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/pwb_issue.sv
module pwb_issue
  import pwb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int BW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    count_i,
  input  logic             blk_i,
  input  ent_t             head_i,
  input  logic             wr_rdy_i,
  output logic             pop_o,
  output logic             blk_done_o,
  output logic [BUS_W-1:0] ad_o,
  output logic [7:0]       cmd_o,
  output logic             drv_o
);
  localparam logic [BW-1:0] LAST_BEAT = BW'(DEPTH - 1);

  iss_st_e       st_q;
  logic [BW-1:0] beat_q;
  logic          blk_q;
  logic          start, last;

  assign start = (count_i != '0) && (!blk_i || count_i == CW'(DEPTH));
  assign last  = !blk_q || (beat_q == LAST_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      blk_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_ADDR;
          beat_q <= '0;
          blk_q  <= blk_i;
        end
        ST_ADDR: if (wr_rdy_i) st_q <= ST_DATA;
        ST_DATA: begin
          if (last) st_q <= ST_IDLE;
          else      beat_q <= beat_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pop_o      = (st_q == ST_DATA);
  assign blk_done_o = pop_o && blk_q && last;
  assign drv_o      = (st_q != ST_IDLE);

  always_comb begin
    ad_o  = '0;
    cmd_o = '0;
    case (st_q)
      ST_ADDR: begin
        ad_o  = head_i.addr;
        cmd_o = {1'b0, blk_q ? TYP_BLOCK : TYP_SINGLE, 1'b0,
                 blk_q ? 3'b000 : head_i.nb_m1};
      end
      ST_DATA: begin
        ad_o  = head_i.data;
        cmd_o = {1'b1, 3'b000, last, 3'b000};
      end
      default: ;
    endcase
  end

  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && !wr_rdy_i) |=> (st_q == ST_ADDR && $stable(ad_o)));
  p_block_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && blk_q) |-> (count_i == CW'(DEPTH)));
  p_data_flow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && !last) |=> (st_q == ST_DATA));
endmodule

// File: rtl/pwb_check.sv
module pwb_check
  import pwb_pkg::*;
#(
  parameter int W = BUS_W,
  localparam int LANES = W / 8
) (
  input  logic [W-1:0]     ad_i,
  input  logic [7:0]       cmd_i,
  output logic [LANES-1:0] chk_o,
  output logic [8:0]       cmd_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign chk_o[g] = ^ad_i[8*g +: 8];
  end
  assign cmd_o = {^cmd_i, cmd_i};
endmodule

// File: rtl/post_write_buffer.sv
module post_write_buffer
  import pwb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic               wr_block_i,
  input  logic [BUS_W-1:0]   wr_addr_i,
  input  logic [BUS_W-1:0]   wr_data_i,
  input  logic [NB_W-1:0]    wr_nb_m1_i,
  output logic               wr_stall_o,
  input  logic               wr_rdy_i,
  output logic [BUS_W-1:0]   sys_ad_o,
  output logic [BUS_W/8-1:0] sys_chk_o,
  output logic [8:0]         sys_cmd_o,
  output logic               sys_drv_o
);
  localparam int CW = $clog2(DEPTH + 1);

  ent_t          wr_ent, head;
  logic [CW-1:0] count, ld_cnt_q;
  logic          push, pop, blk_done, lock;
  logic [7:0]    cmd_raw;

  assign lock = (ld_cnt_q != '0);

  always_comb begin
    if (lock)            wr_stall_o = !wr_block_i || (ld_cnt_q == CW'(DEPTH));
    else if (wr_block_i) wr_stall_o = (count != '0);
    else                 wr_stall_o = (count == CW'(DEPTH));
  end

  assign push   = wr_valid_i && !wr_stall_o;
  assign wr_ent = '{addr: wr_addr_i, data: wr_data_i, nb_m1: wr_nb_m1_i};

  // beats of the current line writeback accepted so far
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ld_cnt_q <= '0;
    else if (blk_done)            ld_cnt_q <= '0;
    else if (push && wr_block_i)  ld_cnt_q <= ld_cnt_q + 1'b1;
  end

  pwb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .entry_i(wr_ent), .pop_i(pop),
    .head_o(head), .count_o(count)
  );

  pwb_issue #(.DEPTH(DEPTH)) u_issue (
    .clk_i, .rst_ni, .count_i(count), .blk_i(lock), .head_i(head),
    .wr_rdy_i, .pop_o(pop), .blk_done_o(blk_done), .ad_o(sys_ad_o),
    .cmd_o(cmd_raw), .drv_o(sys_drv_o)
  );

  pwb_check #(.W(BUS_W)) u_check (
    .ad_i(sys_ad_o), .cmd_i(cmd_raw), .chk_o(sys_chk_o), .cmd_o(sys_cmd_o)
  );

  p_idle_cmd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_drv_o |-> (sys_cmd_o == 9'd0));
  p_cmd_parity_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_drv_o |-> (^sys_cmd_o == 1'b0));
  p_no_single_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !wr_block_i) |-> (ld_cnt_q == '0));
endmodule

// File: tb/post_write_buffer_test.sv
`timescale 1ns/1ps
module post_write_buffer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0, wr_block_i = 1'b0;
  logic [63:0] wr_addr_i = '0, wr_data_i = '0;
  logic [2:0]  wr_nb_m1_i = '0;
  logic        wr_stall_o, wr_rdy_i, sys_drv_o;
  logic [63:0] sys_ad_o;
  logic [7:0]  sys_chk_o;
  logic [8:0]  sys_cmd_o;

  post_write_buffer uut (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {logic [63:0] ad; logic [8:0] cmd;} cyc_t;
  cyc_t exp_q[$];
  int checks = 0, errors = 0;
  int rdy_mode = 0;   // 0 low, 1 high, 2 pseudo-random
  logic [7:0] lfsr = 8'hA5;

  function automatic logic [8:0] mk_cmd(input logic [7:0] c);
    return {^c, c};
  endfunction

  function automatic logic [7:0] lane_par(input logic [63:0] v);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^v[8*i +: 8];
    return p;
  endfunction

  task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // write-ready driver
  initial begin
    wr_rdy_i = 1'b0;
    forever begin
      @(posedge clk_i); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_rdy_i = (rdy_mode == 1) || (rdy_mode == 2 && lfsr[0]);
    end
  end

  // monitor / scoreboard
  initial begin
    cyc_t last_c, e;
    logic hold = 1'b0, in_blk_data = 1'b0;
    string tag;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) continue;
      if (!sys_drv_o) begin
        check("R5/R10 bus dropped", !hold && !in_blk_data, {63'd0, hold}, 64'd0);
        hold = 1'b0;
        in_blk_data = 1'b0;
        continue;
      end
      check("R6", sys_chk_o == lane_par(sys_ad_o), {56'd0, sys_chk_o}, {56'd0, lane_par(sys_ad_o)});
      check("R7", ^sys_cmd_o == 1'b0, {55'd0, sys_cmd_o}, 64'd0);
      if (in_blk_data) check("R10", sys_cmd_o[7] == 1'b1, {55'd0, sys_cmd_o}, 64'h80);
      if (hold) begin
        check("R5 ad", sys_ad_o == last_c.ad, sys_ad_o, last_c.ad);
        check("R5 cmd", sys_cmd_o == last_c.cmd, {55'd0, sys_cmd_o}, {55'd0, last_c.cmd});
      end else if (exp_q.size() == 0) begin
        check("R3 unexpected cycle", 1'b0, sys_ad_o, 64'd0);
      end else begin
        e = exp_q.pop_front();
        tag = (e.cmd[7] == 1'b0 && e.cmd[6:4] == 3'b010) ? "R8" : "R4";
        check("R3 ad", sys_ad_o == e.ad, sys_ad_o, e.ad);
        check(tag, sys_cmd_o == e.cmd, {55'd0, sys_cmd_o}, {55'd0, e.cmd});
        last_c.ad = sys_ad_o;
        last_c.cmd = sys_cmd_o;
      end
      hold = !sys_cmd_o[7] && !wr_rdy_i;
      in_blk_data = sys_cmd_o[7] && !sys_cmd_o[3] ? 1'b1 :
                    (!sys_cmd_o[7] && sys_cmd_o[6:4] == 3'b010 && !hold);
    end
  end

  // drive one beat; called at posedge+1, returns at posedge+1 after acceptance
  task automatic drive(input logic [63:0] a, input logic [63:0] d, input logic [2:0] nb, input logic blk);
    wr_valid_i = 1'b1; wr_block_i = blk; wr_addr_i = a; wr_data_i = d; wr_nb_m1_i = nb;
    forever begin
      @(negedge clk_i);
      if (!wr_stall_o) break;
    end
    @(posedge clk_i); #1;
    wr_valid_i = 1'b0; wr_block_i = 1'b0;
  endtask

  task automatic push_single(input logic [63:0] a, input logic [63:0] d, input logic [2:0] nb);
    exp_q.push_back('{ad: a, cmd: mk_cmd({1'b0, 3'b001, 1'b0, nb})});
    exp_q.push_back('{ad: d, cmd: mk_cmd(8'b1000_1000)});
    drive(a, d, nb, 1'b0);
  endtask

  task automatic wait_drain();
    int n = 0;
    while ((exp_q.size() != 0 || sys_drv_o) && n < 2000) begin
      @(posedge clk_i); #1; n++;
    end
    repeat (2) begin @(posedge clk_i); #1; end
  endtask

  task automatic probe_stall(input string req, input logic blk, input logic exp);
    wr_valid_i = 1'b1; wr_block_i = blk; wr_addr_i = 64'hDEAD_0000; wr_data_i = '1;
    @(negedge clk_i);
    check(req, wr_stall_o == exp, {63'd0, wr_stall_o}, {63'd0, exp});
    @(posedge clk_i); #1;
    wr_valid_i = 1'b0; wr_block_i = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    check("watchdog", 1'b0, 64'd0, 64'd1);
    finish_sim();
  end

  initial begin
    logic [63:0] base;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 drv", sys_drv_o == 1'b0, {63'd0, sys_drv_o}, 64'd0);
    check("R1 cmd", sys_cmd_o == 9'd0, {55'd0, sys_cmd_o}, 64'd0);
    check("R1 stall", wr_stall_o == 1'b0, {63'd0, wr_stall_o}, 64'd0);
    @(posedge clk_i); #1;

    // R4: singles of different sizes with write-ready high
    rdy_mode = 1;
    push_single(64'h0000_1000_0000_0000, 64'h0123_4567_89AB_CDEF, 3'd7);
    push_single(64'h0000_0000_0000_2005, 64'h0000_0000_00FF_0000, 3'd0);
    push_single(64'h0000_0000_0000_3002, 64'h0000_0000_FFFF_0000, 3'd1);
    wait_drain();

    // R2/R5: write-ready low, fill four entries, fifth refused
    rdy_mode = 0;
    for (int i = 0; i < 4; i++)
      push_single(64'h4000 + 64'(i * 8), 64'hA5A5_0000_0000_0000 | 64'(i), 3'd7);
    repeat (2) begin @(posedge clk_i); #1; end
    probe_stall("R2 full", 1'b0, 1'b1);
    rdy_mode = 1;
    push_single(64'h5000, 64'hFACE_FACE_FACE_FACE, 3'd3);
    wait_drain();

    // R3/R5: random write-ready over a stream
    rdy_mode = 2;
    for (int i = 0; i < 10; i++)
      push_single(64'h6000_0000 + 64'(i * 16), {32'hC0DE_0000 + 32'(i), 32'(i * 7)}, 3'(i));
    wait_drain();

    // R8: block first beat refused while an entry is held
    rdy_mode = 0;
    push_single(64'h7000, 64'h7777, 3'd7);
    probe_stall("R8 not empty", 1'b1, 1'b1);
    rdy_mode = 1;
    wait_drain();

    // R8/R9/R10: line writeback
    rdy_mode = 0;
    base = 64'h0000_0000_8000_0040;
    exp_q.push_back('{ad: base, cmd: mk_cmd(8'b0010_0000)});
    for (int i = 0; i < 4; i++)
      exp_q.push_back('{ad: 64'hB10C_0000_0000_0000 | 64'(i), cmd: mk_cmd(i == 3 ? 8'b1000_1000 : 8'b1000_0000)});
    drive(base, 64'hB10C_0000_0000_0000, 3'd0, 1'b1);
    drive(base + 8, 64'hB10C_0000_0000_0001, 3'd0, 1'b1);
    probe_stall("R9 load", 1'b0, 1'b1);
    @(negedge clk_i);
    check("R8 no early issue", sys_drv_o == 1'b0, {63'd0, sys_drv_o}, 64'd0);
    @(posedge clk_i); #1;
    drive(base + 16, 64'hB10C_0000_0000_0002, 3'd0, 1'b1);
    drive(base + 24, 64'hB10C_0000_0000_0003, 3'd0, 1'b1);
    probe_stall("R9 fifth beat", 1'b1, 1'b1);
    probe_stall("R9 drain", 1'b0, 1'b1);
    repeat (3) begin @(posedge clk_i); #1; end
    probe_stall("R9 hold addr", 1'b0, 1'b1);
    rdy_mode = 1;
    push_single(64'h9000, 64'h9999_0000_9999_0000, 3'd5);
    wait_drain();

    // second block with random write-ready
    rdy_mode = 2;
    base = 64'h0000_0001_0000_0000;
    exp_q.push_back('{ad: base, cmd: mk_cmd(8'b0010_0000)});
    for (int i = 0; i < 4; i++)
      exp_q.push_back('{ad: 64'h5EC0_0000_0000_0000 + 64'(i), cmd: mk_cmd(i == 3 ? 8'b1000_1000 : 8'b1000_0000)});
    for (int i = 0; i < 4; i++)
      drive(base + 64'(i * 8), 64'h5EC0_0000_0000_0000 + 64'(i), 3'd0, 1'b1);
    push_single(64'hA000, 64'hAAAA, 3'd1);
    wait_drain();

    check("R3 queue empty", exp_q.size() == 0, 64'(exp_q.size()), 64'd0);
    finish_sim();
  end
endmodule